// File: doc/BRIEF.md
# External Horizontal Sync Presence Detector

This block decides whether a horizontal sync stream arriving from outside the chip is live. It counts the rising edges of the incoming sync within a measurement window, and at the end of each window it compares the count with a programmable threshold. A judgment flag stays high while sync is considered present. A one-cycle pulse marks every change of that flag, so a downstream sync source selector can react to it without tracking the flag's previous value.

The threshold comes from a 4-bit select field. Each bit stands for a pulse count: bit 0 means 16, bit 1 means 32, bit 2 means 64 and bit 3 means 128. An all-zero field turns detection off. The window lasts 1.25 times the threshold, counted in nominal line periods. A line period is a parameter given in system clocks. A stream that arrives at the nominal line rate therefore produces 25 % more pulses than the threshold needs. The sync input may be asynchronous to the system clock, because it passes through a two-flop synchroniser first. The block has no data stream, so every pin is a plain level or pulse and none has a handshake.

Top module: `sync_presence_detector`

## Requirements
- R1: After reset, present_o and change_o are 0.
- R2: While thr_sel is 4'b0000, detection is off. present_o is 0 from the clock edge after thr_sel becomes zero, the window and the pulse count stay idle, and sync pulses have no effect on the output.
- R3: The threshold is 16 for thr_sel 4'b0001, 32 for 4'b0010, 64 for 4'b0100 and 128 for 4'b1000. Bit 0 is the least significant bit.
- R4: A window lasts (threshold × LINE_CLKS × 5 / 4) clocks. The default LINE_CLKS is 16, which gives 320, 640, 1280 and 2560 clocks. present_o changes only at the end of a window or when detection is turned off.
- R5: At the end of a window, present_o becomes 1 if the number of pulses counted in that window is at least the threshold, so a count equal to the threshold is enough. Otherwise present_o becomes 0.
- R6: Each sync pulse is counted once, on its synchronised rising edge, whatever its width.
- R7: change_o is high for exactly one clock, in the same cycle in which present_o takes its new value, and only when present_o toggles.
- R8: A nonzero thr_sel with more than one bit set selects the threshold of its highest set bit.
- R9: A change of the selected threshold restarts the window and clears the count. present_o keeps its value until the new window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hsync_in | input | 1 | External horizontal sync pulse, may be asynchronous |
| thr_sel | input | 4 | Threshold select, one-hot; zero disables detection |
| present_o | output | 1 | High while external sync is judged present |
| change_o | output | 1 | One-cycle pulse on each toggle of present_o |

## Verification
The assertions check four rules on every cycle:
- the flag is held low while the select field is zero;
- the flag rises only while detection is enabled;
- the flag moves only at a window end or when detection is turned off;
- the change pulse is exactly one cycle wide and coincides with each toggle.

Only the bench scenarios can show the rest:
- that each code gives its own window length, observed as the first rise falling between two time marks;
- that a count exactly equal to the threshold still counts as presence;
- that wide pulses are counted once;
- that a mixed code follows its highest bit;
- that a threshold change restarts the window without dropping the flag.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int unsigned SP_LEVELS = 4;
  localparam int unsigned SP_LVL_W  = $clog2(SP_LEVELS);

  typedef struct packed {
    logic                en;
    logic [SP_LVL_W-1:0] lvl;
  } thr_sel_t;

endpackage

// File: rtl/sp_thr_decode.sv
module sp_thr_decode
  import sp_pkg::*;
(
  input  logic [SP_LEVELS-1:0] code,
  output thr_sel_t             sel
);

  // Scan upward so that the highest set bit wins for codes with several bits set.
  always_comb begin
    sel = '0;
    for (int i = 0; i < SP_LEVELS; i++) begin
      if (code[i]) begin
        sel.en  = 1'b1;
        sel.lvl = SP_LVL_W'(i);
      end
    end
  end

endmodule

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  // The last bit is the previous value of the synchronised signal.
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/sp_window_timer.sv
module sp_window_timer
  import sp_pkg::*;
#(
  parameter int unsigned LINE_CLKS = 16,
  parameter int unsigned BASE_THR  = 16,
  parameter int unsigned WIN_NUM   = 5,
  parameter int unsigned WIN_DEN   = 4,
  localparam int unsigned MAX_WIN  =
    ((BASE_THR << (SP_LEVELS-1)) * LINE_CLKS * WIN_NUM) / WIN_DEN,
  localparam int unsigned WIN_W    = $clog2(MAX_WIN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                restart,
  input  logic [SP_LVL_W-1:0] lvl,
  output logic                win_end
);

  logic [WIN_W-1:0] limit;
  logic [WIN_W-1:0] tick;

  // Window length for each level: threshold x 1.25 line periods.
  always_comb begin
    limit = '0;
    for (int i = 0; i < SP_LEVELS; i++) begin
      if (lvl == SP_LVL_W'(i))
        limit = WIN_W'(((BASE_THR << i) * LINE_CLKS * WIN_NUM) / WIN_DEN);
    end
  end

  assign win_end = run && !restart && (tick == limit - WIN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tick <= '0;
    else if (!run || restart)  tick <= '0;
    else if (win_end)          tick <= '0;
    else                       tick <= tick + WIN_W'(1);
  end

endmodule

// File: rtl/sp_pulse_counter.sv
module sp_pulse_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (clear)                    count <= '0;
    else if (inc && count != CNT_MAX)  count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/sync_presence_detector.sv
module sync_presence_detector
  import sp_pkg::*;
#(
  parameter int unsigned LINE_CLKS   = 16,
  parameter int unsigned BASE_THR    = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WIN_NUM    = 5,
  localparam int unsigned WIN_DEN    = 4,
  localparam int unsigned CNT_W      = $clog2((BASE_THR << (SP_LEVELS-1)) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hsync_in,
  input  logic [SP_LEVELS-1:0] thr_sel,
  output logic                 present_o,
  output logic                 change_o
);

  thr_sel_t            sel;
  logic                en_q;
  logic [SP_LVL_W-1:0] lvl_q;
  logic                run;
  logic                restart;
  logic                hs_rise;
  logic                win_end;
  logic [CNT_W-1:0]    pulses;
  logic [CNT_W:0]      total;
  logic [CNT_W:0]      thr_val;
  logic                present_d;
  logic                present_q;
  logic                change_q;

  sp_thr_decode u_decode (
    .code (thr_sel),
    .sel  (sel)
  );

  sp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (hsync_in),
    .rise     (hs_rise)
  );

  assign run     = sel.en;
  assign restart = run && (!en_q || (lvl_q != sel.lvl));

  sp_window_timer #(
    .LINE_CLKS (LINE_CLKS),
    .BASE_THR  (BASE_THR),
    .WIN_NUM   (WIN_NUM),
    .WIN_DEN   (WIN_DEN)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .lvl     (sel.lvl),
    .win_end (win_end)
  );

  sp_pulse_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!run || restart || win_end),
    .inc   (hs_rise && run && !restart),
    .count (pulses)
  );

  // A pulse seen in the last cycle of a window still belongs to that window.
  assign total   = {1'b0, pulses} + (CNT_W+1)'(hs_rise);
  assign thr_val = (CNT_W+1)'(BASE_THR) << sel.lvl;

  always_comb begin
    if (!run)         present_d = 1'b0;
    else if (win_end) present_d = (total >= thr_val);
    else              present_d = present_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      lvl_q     <= '0;
      present_q <= 1'b0;
      change_q  <= 1'b0;
    end else begin
      en_q      <= sel.en;
      lvl_q     <= sel.lvl;
      present_q <= present_d;
      change_q  <= present_d ^ present_q;
    end
  end

  assign present_o = present_q;
  assign change_o  = change_q;

endmodule

// File: rtl/sp_presence_checker.sv
module sp_presence_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] thr_sel,
  input logic       present_o,
  input logic       change_o,
  input logic       win_end
);

  p_off_holds_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_sel == 4'd0) |=> !present_o);

  p_moves_at_window_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && thr_sel != 4'd0) |=> $stable(present_o));

  p_rise_only_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present_o) |-> ($past(thr_sel) != 4'd0));

  p_change_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |=> !change_o);

  p_change_marks_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (change_o == (present_o != $past(present_o))));

endmodule

bind sync_presence_detector sp_presence_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .thr_sel   (thr_sel),
  .present_o (present_o),
  .change_o  (change_o),
  .win_end   (win_end)
);

// File: tb/test_sync_presence_detector.sv
module test_sync_presence_detector;

  localparam int CLK_PERIOD = 10;
  localparam int LINE       = 16;
  localparam int MARGIN     = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic [3:0] thr_sel = 4'd0;
  logic       present_o;
  logic       change_o;

  int n_cmp = 0;
  int n_bad = 0;
  int hs_period = 0;
  int hs_width = 3;
  int phase = 0;
  bit done = 1'b0;
  bit exp_q[$];

  sync_presence_detector #(.LINE_CLKS(LINE)) i_sync_presence_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_in  (hsync_in),
    .thr_sel   (thr_sel),
    .present_o (present_o),
    .change_o  (change_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Free-running sync pulse source.
  initial forever begin
    @(negedge clk);
    if (hs_period > 0) begin
      phase    = (phase >= hs_period - 1) ? 0 : phase + 1;
      hsync_in = (phase < hs_width);
    end else begin
      phase    = 0;
      hsync_in = 1'b0;
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: every change pulse consumes one expected flag value.
  always @(negedge clk) begin
    if (rst_n && change_o && !done) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7: got unexpected change to %0b expected no change at %0t",
                 present_o, $time);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (present_o !== e) begin
          n_bad++;
          $display("FAIL R7: got flag %0b expected %0b at %0t", present_o, e, $time);
        end
      end
    end
  end

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int win_len(int thr);
    return thr * LINE * 5 / 4;
  endfunction

  // Enable with code from the off state and check the first rise falls between the marks.
  task automatic enable_and_time(string req, logic [3:0] code, int thr);
    exp_q.push_back(1'b1);
    thr_sel = code;
    wait_clks(win_len(thr) - MARGIN);
    check(req, present_o, 1'b0);
    wait_clks(2 * MARGIN);
    check(req, present_o, 1'b1);
  endtask

  task automatic turn_off();
    exp_q.push_back(1'b0);
    thr_sel = 4'd0;
    wait_clks(1);
    check("R2", present_o, 1'b0);
    check("R7", change_o, 1'b1);
    wait_clks(1);
    check("R7", change_o, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clks(3);
    check("R1", present_o, 1'b0);
    check("R1", change_o, 1'b0);
    rst_n = 1'b1;
    wait_clks(2);

    // R2: pulses while off have no effect.
    hs_period = 20;
    hs_width  = 3;
    wait_clks(3000);
    check("R2", present_o, 1'b0);

    // R3, R4, R5: period 20 gives exactly the threshold in every window.
    enable_and_time("R3_16", 4'b0001, 16);
    turn_off();
    enable_and_time("R3_32", 4'b0010, 32);
    turn_off();
    enable_and_time("R3_64", 4'b0100, 64);
    turn_off();
    enable_and_time("R4_128", 4'b1000, 128);

    // R9: a threshold change restarts the window and keeps the flag.
    thr_sel   = 4'b0001;
    wait_clks(3 * win_len(16));
    check("R5", present_o, 1'b1);
    exp_q.push_back(1'b0);
    thr_sel   = 4'b1000;
    hs_period = 22;
    wait_clks(win_len(128) - MARGIN);
    check("R9", present_o, 1'b1);
    wait_clks(2 * MARGIN);
    check("R9", present_o, 1'b0);

    // R5: no pulses keeps the flag low.
    hs_period = 0;
    wait_clks(2 * win_len(128));
    check("R5", present_o, 1'b0);
    thr_sel = 4'd0;
    wait_clks(2);

    // R8: mixed codes follow the highest set bit.
    hs_period = 20;
    enable_and_time("R8_0110", 4'b0110, 64);
    turn_off();
    enable_and_time("R8_1011", 4'b1011, 128);
    turn_off();

    // R6: wide pulses are counted once each.
    hs_width = 12;
    enable_and_time("R6", 4'b0001, 16);

    // R5: period 22 gives fewer than the threshold.
    exp_q.push_back(1'b0);
    hs_width  = 3;
    hs_period = 22;
    wait_clks(4 * win_len(16));
    check("R5", present_o, 1'b0);

    wait_clks(5);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7: got %0d pending changes expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule